// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the upstream USB line pair and decides when a single-ended zero (both lines low together) has lasted long enough to count as a bus reset. Both raw line levels pass through a two-flop synchroniser. A saturating counter then measures how long the condition lasts. The counter is cleared in every cycle where the condition is absent. When the count reaches `THRESH` cycles, a small sequencer takes over. With the default of 168 cycles at 12 MHz, about 14 µs, the threshold sits inside the required 12 to 16 µs window.

On recognition the sequencer does three things at once. It sets a sticky status flag that firmware sees as bit `FLAG_BIT` of its status register. It sends a one-cycle pulse that clears the device address registers. It raises a level that aborts any power-on start-up delay still in progress. The interrupt request does not fire at recognition. It is a single-cycle pulse sent only when the line leaves the single-ended-zero state, that is, at the end of the reset. Software clears the flag by writing a 0 to bit `FLAG_BIT`.

All pins are plain control and status signals. No data stream crosses this block, so it has no valid/ready interface.

Top module: `usb_bus_reset_detector`

## Requirements
- R1: The condition counts only when `dp_in` and `dm_in` are both 0. The line states dp=0/dm=1, dp=1/dm=0 and dp=1/dm=1 never lead to recognition, however long they last.
- R2: A single-ended zero sampled on fewer than `THRESH` consecutive clock edges sets no flag, sends no address clear, raises no abort and sends no interrupt.
- R3: A single-ended zero sampled on `THRESH` consecutive edges is recognised. Let edge 1 be the first edge that samples the condition. Recognition then becomes visible on the outputs after edge `THRESH+3`.
- R4: `addr_clear` is a one-cycle pulse, sent exactly once per recognised reset, in the recognition cycle.
- R5: `reset_seen` rises in the same cycle as `addr_clear` and stays at 1 until software clears it.
- R6: A write with `flag_wr_en`=1 and bit `FLAG_BIT` of `flag_wr_data` equal to 0 clears `reset_seen`. A write with that bit at 1 leaves the flag unchanged. If a recognition and a clearing write arrive in the same cycle, the flag stays at 1.
- R7: `reset_irq` is a single-cycle pulse sent once per recognised reset, never in the recognition cycle. Let the last edge that samples the condition be edge L. The pulse appears after edge max(L, THRESH+1)+3.
- R8: `startup_abort` is high from the recognition cycle until the interrupt cycle, and it falls exactly when `reset_irq` pulses.
- R9: The counter saturates. A single-ended zero far longer than `THRESH` still gives exactly one address clear and one interrupt.
- R10: While `rst_n` is low, and in the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_in | input | 1 | Raw D+ line level, asynchronous |
| dm_in | input | 1 | Raw D- line level, asynchronous |
| flag_wr_en | input | 1 | Write strobe to the status register |
| flag_wr_data | input | REG_W | Write data; bit FLAG_BIT at 0 clears the flag |
| reset_seen | output | 1 | Sticky bus-reset status flag |
| reset_irq | output | 1 | One-cycle interrupt at the end of the bus reset |
| addr_clear | output | 1 | One-cycle pulse that clears the device address registers |
| startup_abort | output | 1 | High while a recognised reset is in progress; aborts the start-up delay |

## Verification
The properties assume that `dp_in` and `dm_in` stay stable for whole clock cycles. They also assume that a raw line level seen three edges before an interrupt still reflects the line leaving the single-ended-zero state. The bench keeps to this: it changes the lines and the write strobe one time unit after a rising edge, and it always holds the line idle for many cycles after a reset ends. Because of this, every duration it applies is an exact count of sampling edges, and the expected edge numbers in R3 and R7 follow directly from that count.

// File: rtl/usb_bus_reset_pkg.sv
package usb_bus_reset_pkg;
  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_ACTIVE = 1'b1
  } seq_state_t;

  localparam int DEFAULT_THRESH = 168;
endpackage

// File: rtl/usbrst_sync.sv
module usbrst_sync #(
  parameter int          WIDTH  = 2,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/usbrst_se0_timer.sv
module usbrst_se0_timer #(
  parameter int THRESH = 168
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  output logic qualified
);
  localparam int CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !se0) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + CNT_W'(1);
  end

  assign qualified = (cnt == LIMIT);
endmodule

// File: rtl/usbrst_sequencer.sv
module usbrst_sequencer
  import usb_bus_reset_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  input  logic qualified,
  input  logic clr_req,
  output logic flag,
  output logic irq,
  output logic addr_clr,
  output logic abort
);
  seq_state_t state;
  logic       enter;

  assign enter = (state == SEQ_IDLE) && qualified;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      irq      <= 1'b0;
      addr_clr <= 1'b0;
    end else begin
      irq      <= 1'b0;
      addr_clr <= 1'b0;
      unique case (state)
        SEQ_IDLE: if (qualified) begin
          state    <= SEQ_ACTIVE;
          addr_clr <= 1'b1;
        end
        SEQ_ACTIVE: if (!se0) begin
          state <= SEQ_IDLE;
          irq   <= 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (enter)   flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  assign abort = (state == SEQ_ACTIVE);
endmodule

// File: rtl/usb_bus_reset_detector.sv
module usb_bus_reset_detector
  import usb_bus_reset_pkg::*;
#(
  parameter int THRESH   = DEFAULT_THRESH,
  parameter int REG_W    = 8,
  parameter int FLAG_BIT = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_in,
  input  logic             dm_in,
  input  logic             flag_wr_en,
  input  logic [REG_W-1:0] flag_wr_data,
  output logic             reset_seen,
  output logic             reset_irq,
  output logic             addr_clear,
  output logic             startup_abort
);
  logic [1:0] lines_s;
  logic       se0_s;
  logic       qual;
  logic       clr_req;

  // lines reset to the idle J state (D+ high) so no SE0 is seen at start
  usbrst_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({dp_in, dm_in}),
    .q    (lines_s)
  );

  assign se0_s   = (lines_s == 2'b00);
  assign clr_req = flag_wr_en && !flag_wr_data[FLAG_BIT];

  usbrst_se0_timer #(.THRESH(THRESH)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .se0      (se0_s),
    .qualified(qual)
  );

  usbrst_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .se0      (se0_s),
    .qualified(qual),
    .clr_req  (clr_req),
    .flag     (reset_seen),
    .irq      (reset_irq),
    .addr_clr (addr_clear),
    .abort    (startup_abort)
  );
endmodule

// File: rtl/usb_bus_reset_checker.sv
module usb_bus_reset_checker #(
  parameter int REG_W    = 8,
  parameter int FLAG_BIT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dp_in,
  input logic             dm_in,
  input logic             flag_wr_en,
  input logic [REG_W-1:0] flag_wr_data,
  input logic             reset_seen,
  input logic             reset_irq,
  input logic             addr_clear,
  input logic             startup_abort
);
  assert_clear_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clear |=> !addr_clear);

  assert_flag_with_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clear |-> reset_seen);

  assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_seen) |-> addr_clear);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_seen && !(flag_wr_en && !flag_wr_data[FLAG_BIT])) |=> reset_seen);

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_irq |=> !reset_irq);

  assert_irq_not_at_recog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_irq |-> !addr_clear);

  assert_irq_after_se0_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_irq |-> $past(dp_in || dm_in, 3));

  assert_abort_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(startup_abort) |-> reset_irq);

  assert_irq_ends_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_irq |-> $past(startup_abort) && !startup_abort);

  assert_abort_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startup_abort) |-> addr_clear);
endmodule

bind usb_bus_reset_detector usb_bus_reset_checker #(
  .REG_W(REG_W), .FLAG_BIT(FLAG_BIT)
) u_checker (.*);

// File: tb/usb_bus_reset_detector_test.sv
module usb_bus_reset_detector_test;
  localparam int T  = 168;
  localparam int NV = 6;
  localparam int VLEN [NV] = '{1, 5, 167, 168, 169, 300};
  localparam bit VEXP [NV] = '{0, 0, 0, 1, 1, 1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dp_in = 1'b1;
  logic       dm_in = 1'b0;
  logic       flag_wr_en = 1'b0;
  logic [7:0] flag_wr_data = 8'h00;
  logic       reset_seen, reset_irq, addr_clear, startup_abort;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int clr_cnt, clr_edge, irq_cnt, irq_edge, abort_cyc;

  always #2 clk = ~clk;

  usb_bus_reset_detector uut (
    .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dm_in(dm_in),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .reset_seen(reset_seen), .reset_irq(reset_irq),
    .addr_clear(addr_clear), .startup_abort(startup_abort)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    dp_in = 1'b1; dm_in = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  // drive a line state on edges 1..len, then idle; record output activity
  task automatic apply(input int len, input bit dp_v, input bit dm_v, input int wr_at);
    clr_cnt = 0; clr_edge = -1; irq_cnt = 0; irq_edge = -1; abort_cyc = 0;
    tick();
    dp_in = dp_v; dm_in = dm_v;
    for (int n = 1; n <= ((len > T) ? len : T) + 12; n++) begin
      tick();
      flag_wr_en = 1'b0;
      if (addr_clear) begin clr_cnt++; if (clr_edge < 0) clr_edge = n; end
      if (reset_irq) begin irq_cnt++; if (irq_edge < 0) irq_edge = n; end
      if (startup_abort) abort_cyc++;
      if (n >= len) begin dp_in = 1'b1; dm_in = 1'b0; end
      if (n == wr_at) begin flag_wr_en = 1'b1; flag_wr_data = 8'h00; end
    end
  endtask

  task automatic write_flag(input logic [7:0] v);
    flag_wr_en = 1'b1; flag_wr_data = v;
    tick();
    flag_wr_en = 1'b0;
  endtask

  initial begin
    // R10: outputs low during and just after reset
    tick(); tick();
    check(!reset_seen && !reset_irq && !addr_clear && !startup_abort, "R10 reset",
          {reset_seen, reset_irq, addr_clear, startup_abort}, 0);
    rst_n = 1'b1;
    tick();
    check(!reset_seen && !reset_irq && !addr_clear && !startup_abort, "R10 post-reset",
          {reset_seen, reset_irq, addr_clear, startup_abort}, 0);
    idle(4);

    for (int v = 0; v < NV; v++) begin
      int L;
      L = VLEN[v];
      apply(L, 1'b0, 1'b0, -1);
      if (VEXP[v]) begin
        int ie;
        ie = ((L > T + 1) ? L : T + 1) + 3;
        check(clr_cnt == 1, "R4/R9 clear count", clr_cnt, 1);
        check(clr_edge == T + 3, "R3 recognition edge", clr_edge, T + 3);
        check(irq_cnt == 1, "R7/R9 irq count", irq_cnt, 1);
        check(irq_edge == ie, "R7 irq edge", irq_edge, ie);
        check(abort_cyc == ie - (T + 3), "R8 abort span", abort_cyc, ie - (T + 3));
        check(reset_seen == 1'b1, "R5 flag sticky", reset_seen, 1);
      end else begin
        check(clr_cnt == 0 && irq_cnt == 0 && abort_cyc == 0, "R2 short SE0",
              clr_cnt + irq_cnt + abort_cyc, 0);
        check(reset_seen == 1'b0, "R2 no flag", reset_seen, 0);
      end
      write_flag(8'h00);
      idle(3);
    end

    // R1: other line states never count
    apply(400, 1'b0, 1'b1, -1);
    check(clr_cnt == 0 && irq_cnt == 0 && !reset_seen, "R1 K state", clr_cnt + irq_cnt, 0);
    apply(400, 1'b1, 1'b1, -1);
    check(clr_cnt == 0 && irq_cnt == 0 && !reset_seen, "R1 SE1 state", clr_cnt + irq_cnt, 0);
    apply(400, 1'b1, 1'b0, -1);
    check(clr_cnt == 0 && irq_cnt == 0 && !reset_seen, "R1 J state", clr_cnt + irq_cnt, 0);

    // R6: write with bit 5 set leaves flag, bit 5 clear clears it
    apply(T, 1'b0, 1'b0, -1);
    check(reset_seen == 1'b1, "R5 flag set", reset_seen, 1);
    write_flag(8'h20);
    check(reset_seen == 1'b1, "R6 write bit5=1 ignored", reset_seen, 1);
    write_flag(8'hDF);
    check(reset_seen == 1'b0, "R6 write bit5=0 clears", reset_seen, 0);

    // R6: set wins over clear in the recognition cycle
    apply(T + 20, 1'b0, 1'b0, T + 2);
    check(clr_edge == T + 3, "R3 recognition edge again", clr_edge, T + 3);
    check(reset_seen == 1'b1, "R6 set beats clear", reset_seen, 1);
    write_flag(8'h00);
    check(reset_seen == 1'b0, "R6 later clear", reset_seen, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule